// File: doc/BRIEF.md
# Multicycle Accumulator Processor Sequencer

This block is a compact processor core that executes each instruction as a short series of register-transfer steps. Each step occupies one clock slot, and four slots make one machine cycle. The control unit walks through a fetch cycle, then an optional pointer-resolving (indirect) cycle, then an execute cycle. Every memory access goes through two staging registers: a memory address register, which drives the address pins, and a memory data register, which receives read data and supplies write data.

The programmer-visible state is a program counter, an instruction register, an accumulator, a base register, a stack pointer and a zero flag. The stack grows toward lower addresses, and its pointer always addresses the next free word. Memory is an external synchronous word RAM. A read strobe in one slot returns data during the next slot, and a write strobe commits the word at the end of its slot. A halt instruction freezes the core so that the final state can be inspected on the observation outputs.

An instruction word has two fields. The opcode sits in the top 4 bits and a 12-bit address/offset field sits in the low bits. The opcodes are:

| Code | Meaning |
|------|---------|
| 1 | add direct |
| 2 | move through a memory pointer |
| 3 | add through the base register |
| 4 | store |
| 5 | jump-if-zero |
| 6 | call |
| 7 | return |
| 8 | push |
| 9 | pop |
| 10 | load base register |
| 15 | halt |
| 0, 11–14 | undefined |

Top module: `acc_cpu`

## Requirements
- R1: While reset is held: pc=0, sp=4095 (all ones), ax=0, zf=1, halted=0, and neither strobe is asserted. The first slot of the first fetch starts two clocks after reset is released.
- R2: Every instruction begins with a 4-slot fetch. Slot 1 copies the program counter into the address register. Slot 2 issues a read. Slot 3 captures the data and adds one to the program counter. Slot 4 loads the instruction register. The total number of clocks and of read strobes equals the sum of the per-instruction costs given in R3–R12.
- R3: Opcode 1 (add direct) adds mem[field] to ax. It takes a 4-slot execute cycle with one read.
- R4: Opcode 2 (move through a pointer) runs a 4-slot indirect cycle that reads mem[field] as a pointer. It then runs a 4-slot execute cycle that reads mem[pointer[11:0]] into ax.
- R5: Opcode 10 loads the base register from mem[field][11:0]. Opcode 3 adds mem[base] to ax. Each takes 4 execute slots with one read.
- R6: Opcode 4 (store) writes ax into mem[field] with one write strobe. It takes 4 execute slots.
- R7: Opcode 5 (jump-if-zero) takes one execute slot. If zf=1, the pc becomes the incremented pc plus the field, taken as a signed 12-bit offset. Otherwise the pc is unchanged.
- R8: Opcode 6 (call) writes the return address into mem[sp], decrements sp, and loads pc with the field. Opcode 7 (return) increments sp, then reads mem[sp] into pc. Each takes 4 execute slots.
- R9: Opcode 8 (push) writes ax into mem[sp] and decrements sp. Opcode 9 (pop) increments sp, then reads mem[sp] into ax. The stack pointer wraps modulo 4096, and any change to it is exactly ±1.
- R10: After every write of ax (add, move, pop), zf is 1 exactly when ax is zero.
- R11: Opcodes 0 and 11–14 change no state and take one execute slot.
- R12: Opcode 15 takes one execute slot and then raises halted. From then on halted stays high, no strobe is issued, and the pc holds the address after the halt instruction.
- R13: The read and write strobes are never asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mem_addr | output | 12 | Memory address (address register) |
| mem_rd | output | 1 | Read strobe; data is expected on mem_rdata in the next cycle |
| mem_wr | output | 1 | Write strobe; mem_wdata is stored at the end of the cycle |
| mem_wdata | output | 16 | Write data (data register) |
| mem_rdata | input | 16 | Read data from memory |
| halted | output | 1 | Core has executed a halt |
| ax | output | 16 | Accumulator |
| pc | output | 12 | Program counter |
| sp | output | 12 | Stack pointer |
| zf | output | 1 | Zero flag |

## Verification
Each read strobe in slot 2 yields data during slot 3, so the bench memory returns read data one clock after the strobe and commits writes at the strobe's edge. An instruction's architectural effects are complete by the end of its last execute slot. The bench therefore counts clocks from reset release and expects halted exactly two clocks plus the summed slot costs later. It compares the final registers, memory and strobe totals only at the falling edge after halted rises. Post-halt checks are taken eight clocks later, to show that nothing moves once the core has stopped.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam int OPC_W    = 4;
  localparam int SLOT_CNT = 4;
  localparam int SLOT_W   = $clog2(SLOT_CNT);

  localparam logic [OPC_W-1:0] OP_ADD   = 4'd1;
  localparam logic [OPC_W-1:0] OP_MOVI  = 4'd2;
  localparam logic [OPC_W-1:0] OP_ADDB  = 4'd3;
  localparam logic [OPC_W-1:0] OP_STORE = 4'd4;
  localparam logic [OPC_W-1:0] OP_JZ    = 4'd5;
  localparam logic [OPC_W-1:0] OP_CALL  = 4'd6;
  localparam logic [OPC_W-1:0] OP_RET   = 4'd7;
  localparam logic [OPC_W-1:0] OP_PUSH  = 4'd8;
  localparam logic [OPC_W-1:0] OP_POP   = 4'd9;
  localparam logic [OPC_W-1:0] OP_LDBX  = 4'd10;
  localparam logic [OPC_W-1:0] OP_HALT  = 4'd15;

  typedef enum logic [2:0] {
    MAR_KEEP, MAR_PC, MAR_IRA, MAR_MBRA, MAR_BX, MAR_SP, MAR_SPUP
  } mar_src_e;

  typedef enum logic [1:0] {
    MBR_KEEP, MBR_MEM, MBR_AX, MBR_PC
  } mbr_src_e;

  typedef enum logic [2:0] {
    PC_KEEP, PC_STEP, PC_REL, PC_IRA, PC_MBRA
  } pc_src_e;

  typedef enum logic [1:0] {
    AX_KEEP, AX_SUM, AX_LOAD
  } ax_src_e;

  typedef enum logic [1:0] {
    SP_KEEP, SP_UP, SP_DOWN
  } sp_src_e;

  typedef enum logic [1:0] {
    CYC_FETCH, CYC_IND, CYC_EXE, CYC_HALT
  } cyc_e;

  typedef struct packed {
    mar_src_e mar;
    mbr_src_e mbr;
    pc_src_e  pc;
    ax_src_e  ax;
    sp_src_e  sp;
    logic     ir_ld;
    logic     bx_ld;
    logic     rd;
    logic     wr;
  } uop_t;

endpackage

// File: rtl/acc_cpu_rstsync.sv
module acc_cpu_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
  import acc_cpu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] ir_opc,
  input  logic [OPC_W-1:0] mbr_opc,
  input  logic             zf,
  output uop_t             uop,
  output logic             halted
);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOT_CNT - 1);
  localparam logic [SLOT_W-1:0] SLOT_T1   = '0;
  localparam logic [SLOT_W-1:0] SLOT_T2   = SLOT_W'(1);
  localparam logic [SLOT_W-1:0] SLOT_T3   = SLOT_W'(2);

  cyc_e              cyc_q, cyc_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              long_op;

  // Opcodes that need all four execute slots
  always_comb begin
    unique case (ir_opc)
      OP_ADD, OP_MOVI, OP_ADDB, OP_LDBX, OP_STORE,
      OP_CALL, OP_RET, OP_PUSH, OP_POP: long_op = 1'b1;
      default:                          long_op = 1'b0;
    endcase
  end

  // Next-state logic
  always_comb begin
    cyc_d  = cyc_q;
    slot_d = slot_q + SLOT_W'(1);
    unique case (cyc_q)
      CYC_FETCH: begin
        if (slot_q == SLOT_LAST) begin
          cyc_d  = (mbr_opc == OP_MOVI) ? CYC_IND : CYC_EXE;
          slot_d = '0;
        end
      end
      CYC_IND: begin
        if (slot_q == SLOT_LAST) begin
          cyc_d  = CYC_EXE;
          slot_d = '0;
        end
      end
      CYC_EXE: begin
        if (slot_q == SLOT_T1 && ir_opc == OP_HALT) begin
          cyc_d  = CYC_HALT;
          slot_d = '0;
        end else if (slot_q == SLOT_LAST || (slot_q == SLOT_T1 && !long_op)) begin
          cyc_d  = CYC_FETCH;
          slot_d = '0;
        end
      end
      default: begin
        cyc_d  = CYC_HALT;
        slot_d = '0;
      end
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q  <= CYC_FETCH;
      slot_q <= '0;
    end else begin
      cyc_q  <= cyc_d;
      slot_q <= slot_d;
    end
  end

  // Micro-operation decode per cycle, slot and opcode
  always_comb begin
    uop = '{mar: MAR_KEEP, mbr: MBR_KEEP, pc: PC_KEEP, ax: AX_KEEP,
            sp: SP_KEEP, ir_ld: 1'b0, bx_ld: 1'b0, rd: 1'b0, wr: 1'b0};
    unique case (cyc_q)
      CYC_FETCH: begin
        unique case (slot_q)
          SLOT_T1: uop.mar = MAR_PC;
          SLOT_T2: uop.rd  = 1'b1;
          SLOT_T3: begin
            uop.mbr = MBR_MEM;
            uop.pc  = PC_STEP;
          end
          default: uop.ir_ld = 1'b1;
        endcase
      end
      CYC_IND: begin
        unique case (slot_q)
          SLOT_T1: uop.mar = MAR_IRA;
          SLOT_T2: uop.rd  = 1'b1;
          SLOT_T3: uop.mbr = MBR_MEM;
          default: ;
        endcase
      end
      CYC_EXE: begin
        unique case (ir_opc)
          OP_ADD, OP_MOVI, OP_ADDB, OP_LDBX: begin
            unique case (slot_q)
              SLOT_T1: uop.mar = (ir_opc == OP_MOVI) ? MAR_MBRA :
                                 (ir_opc == OP_ADDB) ? MAR_BX : MAR_IRA;
              SLOT_T2: uop.rd  = 1'b1;
              SLOT_T3: uop.mbr = MBR_MEM;
              default: begin
                if (ir_opc == OP_LDBX)      uop.bx_ld = 1'b1;
                else if (ir_opc == OP_MOVI) uop.ax    = AX_LOAD;
                else                        uop.ax    = AX_SUM;
              end
            endcase
          end
          OP_POP, OP_RET: begin
            unique case (slot_q)
              SLOT_T1: begin
                uop.mar = MAR_SPUP;
                uop.sp  = SP_UP;
              end
              SLOT_T2: uop.rd  = 1'b1;
              SLOT_T3: uop.mbr = MBR_MEM;
              default: begin
                if (ir_opc == OP_POP) uop.ax = AX_LOAD;
                else                  uop.pc = PC_MBRA;
              end
            endcase
          end
          OP_STORE, OP_PUSH, OP_CALL: begin
            unique case (slot_q)
              SLOT_T1: begin
                uop.mar = (ir_opc == OP_STORE) ? MAR_IRA : MAR_SP;
                uop.mbr = (ir_opc == OP_CALL) ? MBR_PC : MBR_AX;
              end
              SLOT_T2: begin
                uop.wr = 1'b1;
                if (ir_opc != OP_STORE) uop.sp = SP_DOWN;
              end
              SLOT_T3: begin
                if (ir_opc == OP_CALL) uop.pc = PC_IRA;
              end
              default: ;
            endcase
          end
          OP_JZ: begin
            if (slot_q == SLOT_T1 && zf) uop.pc = PC_REL;
          end
          default: ;
        endcase
      end
      default: ;
    endcase
  end

  assign halted = (cyc_q == CYC_HALT);

  // R13
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(uop.rd && uop.wr));

  // R12
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  // R12
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!uop.rd && !uop.wr));
endmodule

// File: rtl/acc_cpu_dpath.sv
module acc_cpu_dpath
  import acc_cpu_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  uop_t              uop,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [OPC_W-1:0]  ir_opc,
  output logic [OPC_W-1:0]  mbr_opc,
  output logic [DATA_W-1:0] ax,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] sp,
  output logic              zf
);
  localparam int PAD_W = DATA_W - ADDR_W;

  logic [ADDR_W-1:0] mar_q, mar_d, pc_q, pc_d, sp_q, sp_d, bx_q;
  logic [DATA_W-1:0] mbr_q, mbr_d, ir_q, ax_q, ax_d;
  logic              zf_q, zf_d;
  logic              mar_en, mbr_en, pc_en, sp_en, ax_en;
  logic [ADDR_W-1:0] ir_field, sp_up;

  assign ir_field = ir_q[ADDR_W-1:0];
  assign sp_up    = sp_q + ADDR_W'(1);

  // Next values and enables
  always_comb begin
    mar_en = (uop.mar != MAR_KEEP);
    unique case (uop.mar)
      MAR_PC:   mar_d = pc_q;
      MAR_IRA:  mar_d = ir_field;
      MAR_MBRA: mar_d = mbr_q[ADDR_W-1:0];
      MAR_BX:   mar_d = bx_q;
      MAR_SP:   mar_d = sp_q;
      MAR_SPUP: mar_d = sp_up;
      default:  mar_d = mar_q;
    endcase

    mbr_en = (uop.mbr != MBR_KEEP);
    unique case (uop.mbr)
      MBR_MEM: mbr_d = mem_rdata;
      MBR_AX:  mbr_d = ax_q;
      MBR_PC:  mbr_d = {{PAD_W{1'b0}}, pc_q};
      default: mbr_d = mbr_q;
    endcase

    pc_en = (uop.pc != PC_KEEP);
    unique case (uop.pc)
      PC_STEP: pc_d = pc_q + ADDR_W'(1);
      PC_REL:  pc_d = pc_q + ir_field;
      PC_IRA:  pc_d = ir_field;
      PC_MBRA: pc_d = mbr_q[ADDR_W-1:0];
      default: pc_d = pc_q;
    endcase

    sp_en = (uop.sp != SP_KEEP);
    unique case (uop.sp)
      SP_UP:   sp_d = sp_up;
      SP_DOWN: sp_d = sp_q - ADDR_W'(1);
      default: sp_d = sp_q;
    endcase

    ax_en = (uop.ax != AX_KEEP);
    ax_d  = (uop.ax == AX_SUM) ? (ax_q + mbr_q) : mbr_q;
    zf_d  = (ax_d == '0);
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mar_q <= '0;
      mbr_q <= '0;
      ir_q  <= '0;
      pc_q  <= '0;
      sp_q  <= '1;
      bx_q  <= '0;
      ax_q  <= '0;
      zf_q  <= 1'b1;
    end else begin
      if (mar_en)    mar_q <= mar_d;
      if (mbr_en)    mbr_q <= mbr_d;
      if (uop.ir_ld) ir_q  <= mbr_q;
      if (pc_en)     pc_q  <= pc_d;
      if (sp_en)     sp_q  <= sp_d;
      if (uop.bx_ld) bx_q  <= mbr_q[ADDR_W-1:0];
      if (ax_en) begin
        ax_q <= ax_d;
        zf_q <= zf_d;
      end
    end
  end

  assign mem_addr  = mar_q;
  assign mem_wdata = mbr_q;
  assign ir_opc    = ir_q[DATA_W-1 -: OPC_W];
  assign mbr_opc   = mbr_q[DATA_W-1 -: OPC_W];
  assign ax        = ax_q;
  assign pc        = pc_q;
  assign sp        = sp_q;
  assign zf        = zf_q;

  // R10
  zf_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ax_q != $past(ax_q)) |-> (zf_q == (ax_q == '0)));

  // R9
  sp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_q != $past(sp_q)) |->
      (sp_q == $past(sp_q) + ADDR_W'(1) || sp_q == $past(sp_q) - ADDR_W'(1)));
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  output logic [ADDR_W-1:0]         mem_addr,
  output logic                      mem_rd,
  output logic                      mem_wr,
  output logic [ADDR_W+OPC_W-1:0]   mem_wdata,
  input  logic [ADDR_W+OPC_W-1:0]   mem_rdata,
  output logic                      halted,
  output logic [ADDR_W+OPC_W-1:0]   ax,
  output logic [ADDR_W-1:0]         pc,
  output logic [ADDR_W-1:0]         sp,
  output logic                      zf
);
  localparam int DATA_W = ADDR_W + OPC_W;

  logic             core_rst_n;
  uop_t             uop;
  logic [OPC_W-1:0] ir_opc, mbr_opc;

  acc_cpu_rstsync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (core_rst_n)
  );

  acc_cpu_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .ir_opc  (ir_opc),
    .mbr_opc (mbr_opc),
    .zf      (zf),
    .uop     (uop),
    .halted  (halted)
  );

  acc_cpu_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .uop       (uop),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .ir_opc    (ir_opc),
    .mbr_opc   (mbr_opc),
    .ax        (ax),
    .pc        (pc),
    .sp        (sp),
    .zf        (zf)
  );

  assign mem_rd = uop.rd;
  assign mem_wr = uop.wr;
endmodule

// File: tb/sim_acc_cpu.sv
module sim_acc_cpu;
  localparam int AW   = 12;
  localparam int DW   = 16;
  localparam int MEMN = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [AW-1:0] mem_addr, pc, sp;
  logic          mem_rd, mem_wr, halted, zf;
  logic [DW-1:0] mem_wdata, mem_rdata, ax;

  acc_cpu u0 (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .halted(halted), .ax(ax), .pc(pc), .sp(sp), .zf(zf)
  );

  logic [DW-1:0] mem  [MEMN];
  logic [DW-1:0] rmem [MEMN];
  logic [DW-1:0] img  [MEMN];

  int checks = 0, failures = 0;
  int rd_cnt = 0, wr_cnt = 0, both_cnt = 0;

  // Synchronous memory model: read data one cycle after the strobe
  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr] = mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr];
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_rd) rd_cnt++;
      if (mem_wr) wr_cnt++;
      if (mem_rd && mem_wr) both_cnt++;
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Bench instruction-level model
  logic [DW-1:0] e_ax;
  logic [AW-1:0] e_bx, e_pc, e_sp;
  logic          e_zf, e_done;
  int            e_slots, e_rd, e_wr;

  task automatic iss();
    logic [DW-1:0] w;
    logic [3:0]    op;
    logic [AW-1:0] a;
    e_ax = '0; e_bx = '0; e_pc = '0; e_sp = '1; e_zf = 1'b1;
    e_done = 1'b0; e_slots = 0; e_rd = 0; e_wr = 0;
    for (int n = 0; n < 3000 && !e_done; n++) begin
      w = rmem[e_pc]; op = w[15:12]; a = w[11:0];
      e_pc = e_pc + 1'b1; e_slots += 4; e_rd++;
      case (op)
        4'd1: begin e_ax = e_ax + rmem[a]; e_zf = (e_ax == 0); e_rd++; e_slots += 4; end
        4'd2: begin e_ax = rmem[rmem[a][11:0]]; e_zf = (e_ax == 0); e_rd += 2; e_slots += 8; end
        4'd3: begin e_ax = e_ax + rmem[e_bx]; e_zf = (e_ax == 0); e_rd++; e_slots += 4; end
        4'd4: begin rmem[a] = e_ax; e_wr++; e_slots += 4; end
        4'd5: begin if (e_zf) e_pc = e_pc + a; e_slots += 1; end
        4'd6: begin rmem[e_sp] = {4'd0, e_pc}; e_sp = e_sp - 1'b1; e_pc = a; e_wr++; e_slots += 4; end
        4'd7: begin e_sp = e_sp + 1'b1; e_pc = rmem[e_sp][11:0]; e_rd++; e_slots += 4; end
        4'd8: begin rmem[e_sp] = e_ax; e_sp = e_sp - 1'b1; e_wr++; e_slots += 4; end
        4'd9: begin e_sp = e_sp + 1'b1; e_ax = rmem[e_sp]; e_zf = (e_ax == 0); e_rd++; e_slots += 4; end
        4'd10: begin e_bx = rmem[a][11:0]; e_rd++; e_slots += 4; end
        4'd15: begin e_slots += 1; e_done = 1'b1; end
        default: e_slots += 1;
      endcase
    end
  endtask

  task automatic clear_img();
    for (int i = 0; i < MEMN; i++) img[i] = '0;
  endtask

  task automatic put(input int addr, input logic [3:0] op, input logic [11:0] f);
    img[addr] = {op, f};
  endtask

  task automatic run(input string tag);
    int cycles, bad, rd0, wr0;
    logic [AW-1:0] pc0;
    rst_n = 1'b0;
    for (int i = 0; i < MEMN; i++) begin mem[i] = img[i]; rmem[i] = img[i]; end
    iss();
    if (!e_done) return;
    @(posedge clk);
    rd_cnt = 0; wr_cnt = 0; both_cnt = 0;
    @(negedge clk);
    rst_n = 1'b1;
    cycles = 0;
    forever begin
      @(posedge clk); cycles++;
      @(negedge clk);
      if (halted) break;
      if (cycles > 20000) break;
    end
    check(halted == 1'b1, "R12", "halted raised", halted, 1);
    check(cycles == e_slots + 2, "R2", "clocks to halt", cycles, e_slots + 2);
    check(rd_cnt == e_rd, "R2", "read strobes", rd_cnt, e_rd);
    check(wr_cnt == e_wr, "R6", "write strobes", wr_cnt, e_wr);
    check(ax == e_ax, tag, "ax", ax, e_ax);
    check(zf == e_zf, "R10", "zf", zf, e_zf);
    check(sp == e_sp, tag, "sp", sp, e_sp);
    check(pc == e_pc, tag, "pc", pc, e_pc);
    bad = 0;
    for (int i = 0; i < MEMN; i++) if (mem[i] !== rmem[i]) bad++;
    check(bad == 0, tag, "memory mismatches", bad, 0);
    rd0 = rd_cnt; wr0 = wr_cnt; pc0 = pc;
    repeat (8) @(negedge clk);
    check(halted && rd_cnt == rd0 && wr_cnt == wr0, "R12", "strobes after halt",
          rd_cnt + wr_cnt, rd0 + wr0);
    check(pc == pc0, "R12", "pc after halt", pc, pc0);
    check(both_cnt == 0, "R13", "cycles with both strobes", both_cnt, 0);
  endtask

  task automatic data_init();
    img[12'h300] = 16'h0005;
    img[12'h301] = 16'hFFFB;
    img[12'h312] = 16'h0000;
  endtask

  int seed_tmp;
  initial begin : watchdog
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    seed_tmp = $urandom(32'h5A17);
    repeat (3) @(negedge clk);
    // R1 reset state
    check(pc == 0, "R1", "pc in reset", pc, 0);
    check(sp == 12'hFFF, "R1", "sp in reset", sp, 12'hFFF);
    check(ax == 0 && zf == 1'b1, "R1", "ax/zf in reset", {ax, zf}, 1);
    check(!halted && !mem_rd && !mem_wr, "R1", "halted/strobes in reset",
          {halted, mem_rd, mem_wr}, 0);

    // R3 add direct, result returns to zero (R10)
    clear_img(); data_init();
    put(0, 4'd1, 12'h300); put(1, 4'd1, 12'h300); put(2, 4'd1, 12'h301);
    put(3, 4'd1, 12'h301); put(4, 4'd15, 0);
    run("R3");

    // R4 move through pointer
    clear_img(); img[12'h310] = 16'h0320; img[12'h320] = 16'h1234;
    put(0, 4'd2, 12'h310); put(1, 4'd15, 0);
    run("R4");

    // R5 base register load and indirect add
    clear_img(); img[12'h311] = 16'h7321; img[12'h321] = 16'h0007;
    put(0, 4'd10, 12'h311); put(1, 4'd3, 0); put(2, 4'd3, 0); put(3, 4'd15, 0);
    run("R5");

    // R6 stores
    clear_img(); img[12'h310] = 16'h0320; img[12'h320] = 16'hBEEF;
    put(0, 4'd2, 12'h310); put(1, 4'd4, 12'h330); put(2, 4'd4, 12'h331); put(3, 4'd15, 0);
    run("R6");

    // R7 taken forward and backward jumps
    clear_img(); data_init();
    put(0, 4'd1, 12'h312); put(1, 4'd5, 12'd2); put(2, 4'd0, 0); put(3, 4'd15, 0);
    put(4, 4'd5, 12'hFFE); put(5, 4'd15, 0);
    run("R7");

    // R7 not taken
    clear_img(); data_init();
    put(0, 4'd1, 12'h300); put(1, 4'd5, 12'd3); put(2, 4'd15, 0); put(5, 4'd15, 0);
    run("R7");

    // R8 call / return
    clear_img(); data_init();
    put(0, 4'd6, 12'h200); put(1, 4'd15, 0);
    put(12'h200, 4'd1, 12'h300); put(12'h201, 4'd7, 0);
    run("R8");

    // R9 push / pop with wrap past the top of memory
    clear_img(); data_init();
    put(0, 4'd1, 12'h300); put(1, 4'd8, 0); put(2, 4'd8, 0); put(3, 4'd1, 12'h301);
    put(4, 4'd9, 0); put(5, 4'd9, 0); put(6, 4'd9, 0); put(7, 4'd15, 0);
    run("R9");

    // R11 undefined opcodes
    clear_img(); data_init();
    put(0, 4'd1, 12'h300); put(1, 4'd0, 12'h123); put(2, 4'd11, 12'h300);
    put(3, 4'd12, 0); put(4, 4'd13, 12'hFFF); put(5, 4'd14, 12'h301); put(6, 4'd15, 0);
    run("R11");

    // Random programs
    for (int p = 0; p < 8; p++) begin
      clear_img();
      for (int i = 12'h300; i < 12'h340; i++) img[i] = 16'($urandom);
      if (p % 2 == 0) for (int i = 12'h300; i < 12'h340; i += 3) img[i] = '0;
      put(12'h200, 4'd1, 12'h301); put(12'h201, 4'd7, 0);
      for (int i = 0; i < 24; i++) begin
        int k;
        k = $urandom % 11;
        case (k)
          0: put(i, 4'd1, 12'(12'h300 + $urandom % 64));
          1: put(i, 4'd2, 12'(12'h300 + $urandom % 64));
          2: put(i, 4'd3, 0);
          3: put(i, 4'd10, 12'(12'h300 + $urandom % 64));
          4: put(i, 4'd4, 12'(12'h300 + $urandom % 64));
          5: put(i, 4'd5, 12'($urandom % 4));
          6: put(i, 4'd6, 12'h200);
          7: put(i, 4'd8, 0);
          8: put(i, 4'd9, 0);
          9: put(i, 4'(11 + $urandom % 4), 12'($urandom));
          default: put(i, 4'd1, 12'h312);
        endcase
      end
      for (int i = 24; i < 30; i++) put(i, 4'd15, 0);
      run("R3");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule